// File: doc/BRIEF.md
# RGB panel timing generator

This block drives the timing side of a parallel RGB display link. From a system clock it derives a pixel strobe at a programmable integer ratio. It then walks each line and each frame through four segments in a fixed order: sync, back porch, active, front porch. From that walk it produces horizontal sync, vertical sync and a data-enable, together with the zero-based column and row of the pixel being shown. It also raises a one-cycle frame interrupt at a selectable point in the frame.

All lengths are written through a small 16-bit register write port, and every count is stored as its value minus one. Timing, size and divider fields are double-buffered. A write lands in a pending copy, and that copy only takes over at the boundary between frames, so a frame in progress never sees a half-updated mode. Polarity and interrupt-position fields act at once. Output starts once both the run bit and its per-frame companion are set. Dropping either bit lets the frame in progress complete before the outputs fall idle.

Top module: `lcd_timing_gen`

## Requirements
- R1: Register 1 holds horizontal sync width minus one in bits [7:0] and horizontal back porch minus one in bits [15:8]; register 2 bits [7:0] hold horizontal front porch minus one. A line is sync, back porch, active and front porch pixels in that order, and hsync is active for the sync pixels at the start of every line.
- R2: Register 2 bits [15:8] hold vertical sync lines minus one; register 3 holds vertical back porch minus one in bits [7:0] and vertical front porch minus one in bits [15:8]. A frame is sync, back porch, active and front porch lines in that order, and vsync is active for whole lines at the start of the frame.
- R3: Register 4 holds active width minus one and register 5 active height minus one; the data-enable is active exactly on the active pixels of the active lines.
- R4: While the data-enable is active, pix_x and pix_y give the zero-based column and row; both are zero otherwise.
- R5: Register 0 bits [15:8] hold the pixel divider minus one; pix_strobe pulses for one clock every divider clocks and each pixel lasts that many clocks. A stored 0 gives a pixel every clock, and a stored 255 gives 256 clocks per pixel.
- R6: Register 0 bits 4, 5, 6 and 7 invert hsync, vsync, de and pix_strobe respectively, with immediate effect, including while idle.
- R7: Output starts only when register 0 bit 0 (run) and bit 1 (per-frame run) are both set; with only one of them set, nothing toggles.
- R8: Timing, size and divider values written while running take effect at the first frame that starts after the write.
- R9: Clearing either run bit lets the current frame finish; the outputs then stay idle.
- R10: frame_irq is a one-clock pulse on the first clock of the vertical segment chosen by register 0 bits [3:2]: 0 front porch, 1 sync, 2 back porch, 3 active.
- R11: After reset the generator is idle and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 to 5) |
| cfg_wdata | input | 16 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity selectable |
| vsync | output | 1 | Vertical sync, polarity selectable |
| de | output | 1 | Data enable, polarity selectable |
| pix_strobe | output | 1 | One-clock pixel strobe, polarity selectable |
| pix_x | output | 16 | Column inside the active area |
| pix_y | output | 16 | Row inside the active area |
| frame_irq | output | 1 | One-clock frame interrupt pulse |

## Verification
On every clock, the assertions check the following. The data-enable never overlaps a sync segment. The segment position counters stay inside their programmed lengths. The interrupt never lasts two clocks. Running only begins with both run bits set and only ends on a frame boundary. The active timing copy holds still within a frame. Pulse widths, line and frame lengths, data-enable placement, coordinate values, strobe spacing at the divider limits, the selectable interrupt positions, the inversions and the frame-boundary take-over of new values are shown only by the bench's scenarios, which measure whole frames against figures worked out from the programmed lengths.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    localparam int PORCH_W = 8;
    localparam int REG_W   = 2 * PORCH_W;
    localparam int ADDR_W  = 3;
    localparam int CNT_W   = REG_W;
    localparam int DIV_W   = 8;
    localparam int INV_W   = 4;
    localparam int NSEG    = 4;

    localparam int INV_HS   = 0;
    localparam int INV_VS   = 1;
    localparam int INV_DE   = 2;
    localparam int INV_PCLK = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_HTIM   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MIX    = 3'd2;
    localparam logic [ADDR_W-1:0] A_VTIM   = 3'd3;
    localparam logic [ADDR_W-1:0] A_WIDTH  = 3'd4;
    localparam logic [ADDR_W-1:0] A_HEIGHT = 3'd5;

    // segment order inside a line and inside a frame
    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACTV  = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    // fields acting immediately
    typedef struct packed {
        logic             run;
        logic             run_frame;
        logic [1:0]       irq_pos;
        logic [INV_W-1:0] inv;
    } ctrl_t;

    // fields taken over at frame boundaries
    typedef struct packed {
        logic [DIV_W-1:0]   div_m1;
        logic [PORCH_W-1:0] h_sync_m1;
        logic [PORCH_W-1:0] h_back_m1;
        logic [PORCH_W-1:0] h_front_m1;
        logic [PORCH_W-1:0] v_sync_m1;
        logic [PORCH_W-1:0] v_back_m1;
        logic [PORCH_W-1:0] v_front_m1;
        logic [CNT_W-1:0]   width_m1;
        logic [CNT_W-1:0]   height_m1;
    } tim_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              load,
    output ctrl_t             ctrl,
    output tim_t              tim_act
);
    typedef struct packed {
        ctrl_t ctrl;
        tim_t  pend;
        tim_t  act;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    st_d.ctrl.run       = wr_data[0];
                    st_d.ctrl.run_frame = wr_data[1];
                    st_d.ctrl.irq_pos   = wr_data[3:2];
                    st_d.ctrl.inv       = wr_data[4 +: INV_W];
                    st_d.pend.div_m1    = wr_data[REG_W-1 -: DIV_W];
                end
                A_HTIM: begin
                    st_d.pend.h_sync_m1 = wr_data[PORCH_W-1:0];
                    st_d.pend.h_back_m1 = wr_data[REG_W-1 -: PORCH_W];
                end
                A_MIX: begin
                    st_d.pend.h_front_m1 = wr_data[PORCH_W-1:0];
                    st_d.pend.v_sync_m1  = wr_data[REG_W-1 -: PORCH_W];
                end
                A_VTIM: begin
                    st_d.pend.v_back_m1  = wr_data[PORCH_W-1:0];
                    st_d.pend.v_front_m1 = wr_data[REG_W-1 -: PORCH_W];
                end
                A_WIDTH:  st_d.pend.width_m1  = wr_data;
                A_HEIGHT: st_d.pend.height_m1 = wr_data;
                default: ;
            endcase
        end
        if (load) begin
            st_d.act = st_q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign tim_act = st_q.act;
endmodule

// File: rtl/lcd_tg_pixdiv.sv
module lcd_tg_pixdiv
    import lcd_tg_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == lim);
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: with a ratio above one, strobes are never back to back
    a_r5_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0) |=> (!tick || lim == '0));
endmodule

// File: rtl/lcd_tg_segcnt.sv
module lcd_tg_segcnt
    import lcd_tg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   step,
    input  logic [NSEG-1:0][W-1:0] len_m1,
    output seg_e                   seg,
    output logic [W-1:0]           sub,
    output logic                   seg_end
);
    typedef struct packed {
        seg_e         seg;
        logic [W-1:0] sub;
    } st_t;

    st_t        st_q, st_d;
    logic [1:0] seg_nxt;

    always_comb begin
        st_d    = st_q;
        seg_nxt = st_q.seg + 2'd1;
        seg_end = step && !clear && (st_q.sub == len_m1[st_q.seg]);
        if (clear) begin
            st_d.seg = SEG_SYNC;
            st_d.sub = '0;
        end else if (seg_end) begin
            st_d.seg = seg_e'(seg_nxt);
            st_d.sub = '0;
        end else if (step) begin
            st_d.sub = st_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seg: SEG_SYNC, sub: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign seg = st_q.seg;
    assign sub = st_q.sub;

    // R1 / R2: position never runs past the programmed segment length
    a_r1_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (st_q.sub <= len_m1[st_q.seg]));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pix_strobe,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  pix_y,
    output logic              frame_irq
);
    typedef struct packed {
        logic running;
        logic irq;
    } st_t;

    st_t   st_q, st_d;
    ctrl_t ctrl;
    tim_t  tim;

    logic                        load, tick, go;
    logic                        line_end, frame_end;
    logic                        h_end, v_end;
    seg_e                        h_seg, v_seg;
    logic [CNT_W-1:0]            h_sub, v_sub;
    logic [NSEG-1:0][CNT_W-1:0]  h_len, v_len;
    logic [1:0]                  irq_seg, v_after;
    logic                        hs_raw, vs_raw, de_raw;

    lcd_tg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .load    (load),
        .ctrl    (ctrl),
        .tim_act (tim)
    );

    lcd_tg_pixdiv #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.running),
        .lim   (tim.div_m1),
        .tick  (tick)
    );

    assign h_len[0] = CNT_W'(tim.h_sync_m1);
    assign h_len[1] = CNT_W'(tim.h_back_m1);
    assign h_len[2] = tim.width_m1;
    assign h_len[3] = CNT_W'(tim.h_front_m1);
    assign v_len[0] = CNT_W'(tim.v_sync_m1);
    assign v_len[1] = CNT_W'(tim.v_back_m1);
    assign v_len[2] = tim.height_m1;
    assign v_len[3] = CNT_W'(tim.v_front_m1);

    lcd_tg_segcnt #(.W(CNT_W)) u_hcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!st_q.running),
        .step    (tick),
        .len_m1  (h_len),
        .seg     (h_seg),
        .sub     (h_sub),
        .seg_end (h_end)
    );

    lcd_tg_segcnt #(.W(CNT_W)) u_vcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!st_q.running),
        .step    (line_end),
        .len_m1  (v_len),
        .seg     (v_seg),
        .sub     (v_sub),
        .seg_end (v_end)
    );

    always_comb begin
        st_d      = st_q;
        go        = ctrl.run && ctrl.run_frame;
        line_end  = h_end && (h_seg == SEG_FRONT);
        frame_end = v_end && (v_seg == SEG_FRONT);
        v_after   = v_seg + 2'd1;
        irq_seg   = ctrl.irq_pos + 2'd3;
        if (!st_q.running) begin
            st_d.running = go;
        end else if (frame_end) begin
            st_d.running = go;
        end
        st_d.irq = st_d.running &&
                   ((!st_q.running && irq_seg == SEG_SYNC) ||
                    (st_q.running && v_end && v_after == irq_seg));
        load = !st_q.running || frame_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_raw = st_q.running && (h_seg == SEG_SYNC);
    assign vs_raw = st_q.running && (v_seg == SEG_SYNC);
    assign de_raw = st_q.running && (h_seg == SEG_ACTV) && (v_seg == SEG_ACTV);

    assign hsync      = hs_raw ^ ctrl.inv[INV_HS];
    assign vsync      = vs_raw ^ ctrl.inv[INV_VS];
    assign de         = de_raw ^ ctrl.inv[INV_DE];
    assign pix_strobe = tick ^ ctrl.inv[INV_PCLK];
    assign pix_x      = de_raw ? h_sub : '0;
    assign pix_y      = de_raw ? v_sub : '0;
    assign frame_irq  = st_q.irq;

    // R3: data-enable stays clear of both sync segments
    a_r3_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (!hs_raw && !vs_raw));

    // R7: running only begins with both run bits set
    a_r7_start_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.running) |-> $past(ctrl.run && ctrl.run_frame));

    // R9: running only ends on the last clock of a frame
    a_r9_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.running) |-> $past(frame_end));

    // R8: live timing copy is frozen inside a frame
    a_r8_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.running && !frame_end) |=> $stable(tim));

    // R10: the frame interrupt is a single-clock pulse
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |=> !frame_irq);
endmodule

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        hsync, vsync, de, pix_strobe, frame_irq;
    logic [15:0] pix_x, pix_y;

    lcd_timing_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .hsync      (hsync),
        .vsync      (vsync),
        .de         (de),
        .pix_strobe (pix_strobe),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .frame_irq  (frame_irq)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int hs = 2, hbp = 3, hfp = 2, vs = 1, vbp = 2, vfp = 1, wid = 8, hgt = 4, dv = 1;
    logic [3:0] inv = 4'h0;
    logic [1:0] sel = 2'd0;

    // measurements of one frame
    int m_hs_len, m_line, m_de_first, m_de_len, m_de_runs, m_de_total;
    int m_vs_len, m_irq_idx, m_irq_cnt, m_strobes, m_xerr, m_yerr, m_zerr;
    bit m_vs_last, m_vs_next;

    function automatic int lc();
        return (hs + hbp + wid + hfp) * dv;
    endfunction
    function automatic int fc();
        return (vs + vbp + hgt + vfp) * lc();
    endfunction
    function automatic bit hs_a();  return hsync ^ inv[0];      endfunction
    function automatic bit vs_a();  return vsync ^ inv[1];      endfunction
    function automatic bit de_a();  return de ^ inv[2];         endfunction
    function automatic bit stb_a(); return pix_strobe ^ inv[3]; endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(bit run, bit runf);
        logic [7:0] dm1;
        dm1 = 8'(dv - 1);
        return {dm1, inv, sel, runf, run};
    endfunction

    task automatic program_timing();
        wr(3'd1, {8'(hbp - 1), 8'(hs - 1)});
        wr(3'd2, {8'(vs - 1), 8'(hfp - 1)});
        wr(3'd3, {8'(vfp - 1), 8'(vbp - 1)});
        wr(3'd4, 16'(wid - 1));
        wr(3'd5, 16'(hgt - 1));
    endtask

    task automatic sync_frame();
        bit seen0;
        seen0 = !vs_a();
        forever begin
            @(negedge clk);
            if (vs_a()) begin
                if (seen0) break;
            end else begin
                seen0 = 1'b1;
            end
        end
    endtask

    task automatic capture();
        bit hs_open, prev_hs, prev_de;
        int r1, r2, pos;
        m_hs_len = 0; m_line = 0; m_de_first = -1; m_de_len = 0; m_de_runs = 0;
        m_de_total = 0; m_vs_len = 0; m_irq_idx = -1; m_irq_cnt = 0; m_strobes = 0;
        m_xerr = 0; m_yerr = 0; m_zerr = 0;
        hs_open = 1'b1; prev_hs = 1'b0; prev_de = 1'b0; r1 = -1; r2 = -1; pos = 0;
        sync_frame();
        for (int i = 0; i < fc(); i++) begin
            if (i > 0) @(negedge clk);
            if (hs_a() && hs_open) m_hs_len++; else hs_open = 1'b0;
            if (hs_a() && !prev_hs) begin
                if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
            end
            prev_hs = hs_a();
            if (de_a()) begin
                if (!prev_de) begin
                    m_de_runs++; pos = 0;
                    if (m_de_runs == 1) m_de_first = i;
                end
                if (int'(pix_x) != pos / dv) m_xerr++;
                if (int'(pix_y) != m_de_runs - 1) m_yerr++;
                if (m_de_runs == 1) m_de_len++;
                m_de_total++; pos++;
            end else if (pix_x != 0 || pix_y != 0) begin
                m_zerr++;
            end
            prev_de = de_a();
            if (vs_a()) m_vs_len++;
            if (frame_irq) begin
                m_irq_cnt++;
                if (m_irq_idx < 0) m_irq_idx = i;
            end
            if (stb_a()) m_strobes++;
            m_vs_last = vs_a();
        end
        @(negedge clk);
        m_vs_next = vs_a();
        m_line = r2 - r1;
    endtask

    function automatic int irq_expect();
        case (sel)
            2'd0: return (vs + vbp + hgt) * lc();
            2'd1: return 0;
            2'd2: return vs * lc();
            default: return (vs + vbp) * lc();
        endcase
    endfunction

    task automatic expect_frame(string pre);
        check_eq({pre, "R1"}, "hsync width", m_hs_len, hs * dv);
        check_eq({pre, "R1"}, "line period", m_line, lc());
        check_eq({pre, "R2"}, "vsync width", m_vs_len, vs * lc());
        check_eq({pre, "R2"}, "frame period end", int'(m_vs_last), 0);
        check_eq({pre, "R2"}, "frame period next", int'(m_vs_next), 1);
        check_eq({pre, "R3"}, "de first", m_de_first, (vs + vbp) * lc() + (hs + hbp) * dv);
        check_eq({pre, "R3"}, "de length", m_de_len, wid * dv);
        check_eq({pre, "R3"}, "de lines", m_de_runs, hgt);
        check_eq({pre, "R3"}, "de total", m_de_total, wid * hgt * dv);
        check_eq({pre, "R4"}, "x errors", m_xerr, 0);
        check_eq({pre, "R4"}, "y errors", m_yerr, 0);
        check_eq({pre, "R4"}, "idle coordinate errors", m_zerr, 0);
        check_eq({pre, "R5"}, "strobes per frame", m_strobes, fc() / dv);
        check_eq({pre, "R10"}, "irq count", m_irq_cnt, 1);
        check_eq({pre, "R10"}, "irq position", m_irq_idx, irq_expect());
    endtask

    task automatic stop_wait();
        int n;
        n = 2 * fc() + 20;
        wr(3'd0, ctrl_word(1'b0, 1'b0));
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R11", "hsync", int'(hsync), 0);
        check_eq("R11", "vsync", int'(vsync), 0);
        check_eq("R11", "de", int'(de), 0);
        check_eq("R11", "strobe", int'(pix_strobe), 0);
        check_eq("R11", "irq", int'(frame_irq), 0);
        check_eq("R11", "coords", int'(pix_x) + int'(pix_y), 0);
    endtask

    task automatic t_enable_pair();
        int act;
        program_timing();
        for (int k = 0; k < 2; k++) begin
            act = 0;
            wr(3'd0, ctrl_word(k == 0, k == 1));
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (hs_a() || vs_a() || de_a() || stb_a() || frame_irq) act++;
            end
            check_eq("R7", k == 0 ? "activity run only" : "activity frame-run only", act, 0);
        end
        wr(3'd0, ctrl_word(1'b0, 1'b0));
    endtask

    task automatic t_basic();
        wr(3'd0, ctrl_word(1'b1, 1'b1));
        capture();
        expect_frame("basic ");
        stop_wait();
    endtask

    task automatic t_irq_select();
        sel = 2'd1;
        wr(3'd0, ctrl_word(1'b1, 1'b1));
        for (int s = 1; s < 4; s++) begin
            sel = 2'(s);
            wr(3'd0, ctrl_word(1'b1, 1'b1));
            capture();
            check_eq("R10", "irq count sel", m_irq_cnt, 1);
            check_eq("R10", "irq position sel", m_irq_idx, irq_expect());
        end
        stop_wait();
        sel = 2'd0;
    endtask

    task automatic t_divider();
        hs = 3; hbp = 1; wid = 5; hfp = 4; vs = 2; vbp = 1; hgt = 3; vfp = 2; dv = 3;
        program_timing();
        wr(3'd0, ctrl_word(1'b1, 1'b1));
        capture();
        expect_frame("div3 ");
        stop_wait();
        hs = 1; hbp = 1; wid = 1; hfp = 1; vs = 1; vbp = 1; hgt = 1; vfp = 1; dv = 256;
        program_timing();
        wr(3'd0, ctrl_word(1'b1, 1'b1));
        capture();
        expect_frame("div256 ");
        stop_wait();
    endtask

    task automatic t_polarity();
        hs = 2; hbp = 3; hfp = 2; vs = 1; vbp = 2; vfp = 1; wid = 8; hgt = 4; dv = 1;
        program_timing();
        inv = 4'hF;
        wr(3'd0, ctrl_word(1'b0, 1'b0));
        @(negedge clk);
        check_eq("R6", "idle hsync level", int'(hsync), 1);
        check_eq("R6", "idle vsync level", int'(vsync), 1);
        check_eq("R6", "idle de level", int'(de), 1);
        check_eq("R6", "idle strobe level", int'(pix_strobe), 1);
        wr(3'd0, ctrl_word(1'b1, 1'b1));
        capture();
        expect_frame("R6 inverted ");
        stop_wait();
        inv = 4'h0;
        wr(3'd0, ctrl_word(1'b0, 1'b0));
    endtask

    task automatic t_frame_shadow();
        int run_len;
        wr(3'd0, ctrl_word(1'b1, 1'b1));
        capture();
        wr(3'd4, 16'd5);
        run_len = 0;
        while (!de_a()) @(negedge clk);
        while (de_a()) begin
            run_len++;
            @(negedge clk);
        end
        check_eq("R8", "width inside current frame", run_len, wid * dv);
        wid = 6;
        capture();
        expect_frame("R8 next frame ");
    endtask

    task automatic t_stop();
        int runs, rises, late_stb;
        bit prev_de, prev_vs;
        runs = 0; rises = 0; late_stb = 0;
        sync_frame();
        wr(3'd0, ctrl_word(1'b0, 1'b0));
        prev_de = de_a(); prev_vs = vs_a();
        for (int i = 0; i < 2 * fc(); i++) begin
            @(negedge clk);
            if (de_a() && !prev_de) runs++;
            if (vs_a() && !prev_vs) rises++;
            if (i >= fc() && stb_a()) late_stb++;
            prev_de = de_a(); prev_vs = vs_a();
        end
        check_eq("R9", "lines finished after stop", runs, hgt);
        check_eq("R9", "new frames after stop", rises, 0);
        check_eq("R9", "strobes once idle", late_stb, 0);
        check_eq("R9", "idle hsync", int'(hs_a()), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_pair();
        t_basic();
        t_irq_select();
        t_divider();
        t_polarity();
        t_frame_shadow();
        t_stop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule